// File: doc/BRIEF.md
# Shared-Datapath Prime-Field Arithmetic Unit

This block computes modular addition, multiplication and division on wide unsigned operands over an odd modulus. Inversion and reduction come from the same hardware. Inversion is division with the dividend forced to one, and reduction is addition with the second addend forced to zero. Each operation has its own opcode.

A small state machine sequences one datapath. The datapath holds four working registers, one modular adder, one modular subtractor and one halve-mod-M unit. The state machine reads three status flags from the datapath: the two division registers are equal, the accumulator is at or above the modulus, and the last multiplier bit has been reached.

Multiplication scans the multiplier from its most significant bit down. Each bit takes two steps, a double and a conditional add, and each step ends with a conditional subtraction of M. Division uses a binary shift-and-subtract loop, so no multiplier circuit is needed.

The caller pulses `start_i` together with the opcode and operands. All inputs are captured on that edge. The result appears on `y_o` in the single cycle that `done_o` is high.

Top module: `modarith_unit`

## Requirements
- R1: Opcode 0, and the unused codes 5, 6 and 7, return y = (a + b) mod M for a, b < M.
- R2: Opcode 1 returns y = (a * b) mod M for a < M and any b. `done_o` rises exactly 2*WIDTH clock edges after the edge that accepts `start_i`.
- R3: Opcode 2 returns y = a * b^-1 mod M for odd M >= 3, a < M, and 0 < b < M with b coprime to M.
- R4: Opcode 3 returns y = b^-1 mod M. The value on `a_i` has no effect.
- R5: Opcode 4 returns y = a mod M for any a, including a >= M. The value on `b_i` has no effect.
- R6: `done_o` is high for exactly one cycle per accepted operation. `y_o` carries the result in that cycle and keeps it until the next operation is accepted.
- R7: A `start_i` seen from the accepting edge up to and including the cycle where `done_o` is high is ignored. It produces no extra `done_o` and does not change the result.
- R8: `op_i`, `a_i`, `b_i` and `m_i` are sampled only on the accepting edge. Changes to them while busy do not affect the result.
- R9: After reset, `done_o` is 0 and `y_o` is 0.
- R10: Every result presented with `done_o` is below M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation when the unit is idle |
| op_i | input | 3 | Operation select: 0 add, 1 multiply, 2 divide, 3 invert, 4 reduce |
| a_i | input | WIDTH | First operand (dividend or multiplicand) |
| b_i | input | WIDTH | Second operand (divisor or multiplier) |
| m_i | input | WIDTH | Odd modulus |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | WIDTH | Result |

## Verification
The completion pulse and a fresh start strobe can land in the same cycle. In that cycle the unit is still finishing, so the strobe must be dropped rather than launch a new operation. The bench raises `start_i` with different operands in the exact cycle that `done_o` is high. It also raises `start_i` in the middle of a multiplication. The scoreboard then treats any completion that arrives with an empty expectation queue as a failure, and it confirms that `y_o` still holds the earlier result afterwards. Operands are scrambled on every cycle after acceptance so that any late sampling shows up as a wrong result.

// File: rtl/modarith_pkg.sv
package modarith_pkg;

  typedef enum logic [2:0] {
    LD_ADD,
    LD_RED,
    LD_MUL,
    LD_DIV,
    LD_INV
  } ld_e;

  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_SUM,
    STEP_RED,
    STEP_DBL,
    STEP_MACC,
    STEP_DIV
  } step_e;

  typedef struct packed {
    logic  load;
    ld_e   ld;
    step_e step;
  } ctrl_t;

  typedef struct packed {
    logic a_eq_b;
    logic u_ge_m;
    logic bit_last;
  } stat_t;

endpackage

// File: rtl/modarith_modadd.sv
// (x + y) mod m, valid while x + y < 2m
module modarith_modadd #(
  parameter int WIDTH = 163
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] r_o
);
  logic [WIDTH:0] sum;
  logic           ge;

  always_comb begin
    sum = {1'b0, x_i} + {1'b0, y_i};
    ge  = sum >= {1'b0, m_i};
    r_o = ge ? WIDTH'(sum - {1'b0, m_i}) : sum[WIDTH-1:0];
  end
endmodule

// File: rtl/modarith_halve.sv
// h / 2 mod m for odd m, h < m
module modarith_halve #(
  parameter int WIDTH = 163
) (
  input  logic [WIDTH-1:0] h_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] r_o
);
  logic [WIDTH:0] sum;

  always_comb begin
    sum = {1'b0, h_i} + {1'b0, m_i};
    r_o = h_i[0] ? WIDTH'(sum >> 1) : (h_i >> 1);
  end
endmodule

// File: rtl/modarith_dp.sv
module modarith_dp
  import modarith_pkg::*;
#(
  parameter int WIDTH = 163
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output stat_t            stat_o,
  output logic [WIDTH-1:0] y_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] a_q, b_q, u_q, v_q, opd_q, m_q;
  logic [CNT_W-1:0] cnt_q;

  logic [WIDTH-1:0] add_y, add_r;
  logic [WIDTH-1:0] sub_x, sub_y, sub_r, h_in, h_r;
  logic [WIDTH-1:0] dab, dba;
  logic [WIDTH:0]   sd;
  logic             a_gt_b;

  always_comb begin
    case (ctrl_i.step)
      STEP_DBL: add_y = u_q;
      STEP_RED: add_y = '0;
      default:  add_y = opd_q;
    endcase
  end

  modarith_modadd #(.WIDTH(WIDTH)) u_add (
    .x_i(u_q),
    .y_i(add_y),
    .m_i(m_q),
    .r_o(add_r)
  );

  always_comb begin
    a_gt_b = a_q > b_q;
    dab    = a_q - b_q;
    dba    = b_q - a_q;
    sub_x  = a_gt_b ? u_q : v_q;
    sub_y  = a_gt_b ? v_q : u_q;
    sd     = {1'b0, sub_x} - {1'b0, sub_y};
    sub_r  = sd[WIDTH] ? (sd[WIDTH-1:0] + m_q) : sd[WIDTH-1:0];
    if (!a_q[0])      h_in = u_q;
    else if (!b_q[0]) h_in = v_q;
    else              h_in = sub_r;
  end

  modarith_halve #(.WIDTH(WIDTH)) u_halve (
    .h_i(h_in),
    .m_i(m_q),
    .r_o(h_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      u_q   <= '0;
      v_q   <= '0;
      opd_q <= '0;
      m_q   <= '0;
      cnt_q <= '0;
    end else if (ctrl_i.load) begin
      m_q   <= m_i;
      cnt_q <= '0;
      case (ctrl_i.ld)
        LD_RED: begin
          u_q   <= a_i;
          opd_q <= '0;
        end
        LD_MUL: begin
          u_q   <= '0;
          opd_q <= a_i;
          a_q   <= b_i;
        end
        LD_DIV, LD_INV: begin
          a_q <= b_i;
          b_q <= m_i;
          u_q <= (ctrl_i.ld == LD_INV) ? WIDTH'(1) : a_i;
          v_q <= '0;
        end
        default: begin
          u_q   <= a_i;
          opd_q <= b_i;
        end
      endcase
    end else begin
      case (ctrl_i.step)
        STEP_SUM, STEP_RED, STEP_DBL: u_q <= add_r;
        STEP_MACC: begin
          if (a_q[WIDTH-1]) u_q <= add_r;
          a_q   <= a_q << 1;
          cnt_q <= cnt_q + 1'b1;
        end
        STEP_DIV: begin
          if (!a_q[0]) begin
            a_q <= a_q >> 1;
            u_q <= h_r;
          end else if (!b_q[0]) begin
            b_q <= b_q >> 1;
            v_q <= h_r;
          end else if (a_gt_b) begin
            a_q <= dab >> 1;
            u_q <= h_r;
          end else begin
            b_q <= dba >> 1;
            v_q <= h_r;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_o.a_eq_b   = a_q == b_q;
    stat_o.u_ge_m   = u_q >= m_q;
    stat_o.bit_last = cnt_q == CNT_W'(WIDTH - 1);
  end

  assign y_o = u_q;

  // R3
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.step == STEP_DIV) |-> (a_q != '0 && b_q != '0));

  // R10
  u_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.step inside {STEP_DBL, STEP_MACC, STEP_DIV}) |=> (u_q < m_q));
endmodule

// File: rtl/modarith_ctrl.sv
module modarith_ctrl
  import modarith_pkg::*;
#(
  parameter int WIDTH = 163
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  stat_t      stat_i,
  output ctrl_t      ctrl_o,
  output logic       done_o
);
  localparam int LAT_W = $clog2(2 * WIDTH + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SUM,
    S_RED,
    S_DBL,
    S_MACC,
    S_DIV,
    S_FIN
  } state_e;

  state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    ctrl_o.load = 1'b0;
    ctrl_o.ld   = LD_ADD;
    ctrl_o.step = STEP_NONE;
    case (state_q)
      S_IDLE: if (start_i) begin
        ctrl_o.load = 1'b1;
        case (op_i)
          3'd1: begin ctrl_o.ld = LD_MUL; state_d = S_DBL; end
          3'd2: begin ctrl_o.ld = LD_DIV; state_d = S_DIV; end
          3'd3: begin ctrl_o.ld = LD_INV; state_d = S_DIV; end
          3'd4: begin ctrl_o.ld = LD_RED; state_d = S_SUM; end
          default: begin ctrl_o.ld = LD_ADD; state_d = S_SUM; end
        endcase
      end
      S_SUM: begin
        ctrl_o.step = STEP_SUM;
        state_d     = S_RED;
      end
      S_RED: begin
        if (stat_i.u_ge_m) ctrl_o.step = STEP_RED;
        else               state_d     = S_FIN;
      end
      S_DBL: begin
        ctrl_o.step = STEP_DBL;
        state_d     = S_MACC;
      end
      S_MACC: begin
        ctrl_o.step = STEP_MACC;
        state_d     = stat_i.bit_last ? S_FIN : S_DBL;
      end
      S_DIV: begin
        if (stat_i.a_eq_b) state_d     = S_FIN;
        else               ctrl_o.step = STEP_DIV;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign done_o = state_q == S_FIN;

  // latency bookkeeping for the multiply check
  logic [LAT_W-1:0] lat_q;
  logic             mul_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      mul_q <= 1'b0;
    end else begin
      lat_q <= (state_q == S_IDLE) ? '0 : lat_q + 1'b1;
      if (state_q == S_IDLE && start_i) mul_q <= op_i == 3'd1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  mul_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mul_q) |-> (lat_q == LAT_W'(2 * WIDTH)));

  // R10
  fin_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stat_i.u_ge_m);
endmodule

// File: rtl/modarith_unit.sv
module modarith_unit
  import modarith_pkg::*;
#(
  parameter int WIDTH = 163
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output logic             done_o,
  output logic [WIDTH-1:0] y_o
);
  ctrl_t ctrl;
  stat_t stat;

  modarith_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (op_i),
    .stat_i (stat),
    .ctrl_o (ctrl),
    .done_o (done_o)
  );

  modarith_dp #(.WIDTH(WIDTH)) u_dp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctrl_i(ctrl),
    .a_i   (a_i),
    .b_i   (b_i),
    .m_i   (m_i),
    .stat_o(stat),
    .y_o   (y_o)
  );
endmodule

// File: tb/sim_modarith_unit.sv
`timescale 1ns/1ps
module sim_modarith_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [2:0]   op;
  logic [W-1:0] a, b, m;
  logic         done;
  logic [W-1:0] y;

  always #2 clk = ~clk;

  modarith_unit #(.WIDTH(W)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .m_i    (m),
    .done_o (done),
    .y_o    (y)
  );

  int drv_checks = 0, drv_errs = 0, mon_checks = 0, mon_errs = 0;
  int wd_err = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  function automatic longint powmod(longint bs, longint e, longint md);
    longint r = 1;
    longint x = bs % md;
    while (e > 0) begin
      if (e[0]) r = (r * x) % md;
      x = (x * x) % md;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic longint inv_mod(longint bv, longint md);
    return powmod(bv, md - 2, md);  // md prime
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors",
             drv_checks + mon_checks + wd_err, drv_errs + mon_errs + wd_err);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    drv_checks++;
    if (!ok) begin
      drv_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errs++;
        $display("FAIL R7 unexpected done: actual 1 expected 0");
      end else begin
        logic [W-1:0] e;
        string        t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (y !== e) begin
          mon_errs++;
          $display("FAIL %s result: actual %0d expected %0d", t, y, e);
        end
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      wd_err = 1;
      $display("FAIL R6 watchdog: actual no completion expected done");
      report();
      $finish;
    end
  end

  // mode: 0 plain, 1 latency check, 2 start while busy, 3 start in done cycle
  task automatic run_op(input logic [2:0] opc, input longint av, input longint bv,
                        input longint mv, input longint ev, input string tag,
                        input int mode);
    int cnt;
    @(negedge clk);
    op = opc; a = W'(av); b = W'(bv); m = W'(mv); start = 1'b1;
    exp_q.push_back(W'(ev));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    a = W'($urandom); b = W'($urandom); m = W'($urandom); op = 3'($urandom);
    cnt = 1;
    while (done !== 1'b1) begin
      @(negedge clk);
      cnt++;
      if (mode == 2 && cnt == 3) begin
        start = 1'b1; op = 3'd0; a = W'($urandom); b = W'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    check(y < W'(mv), "R10", "result below modulus", y, mv);
    if (mode == 1) check(cnt == 2 * W + 1, "R2", "multiply latency", cnt, 2 * W + 1);
    if (mode == 3) begin
      int dn = 0;
      start = 1'b1; op = 3'd1; a = 16'd5; b = 16'd7; m = W'(mv);
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7", "done after start in done cycle", done, 0);
      repeat (80) begin
        @(negedge clk);
        if (done) dn++;
      end
      check(dn == 0, "R7", "completions after ignored start", dn, 0);
      check(y == W'(ev), "R7", "result kept", y, ev);
    end else begin
      @(negedge clk);
      check(done == 1'b0, "R6", "done pulse width", done, 0);
      check(y == W'(ev), "R6", "result held", y, ev);
    end
  endtask

  initial begin
    longint av, bv, mv;
    longint mods[4] = '{65521, 32749, 257, 13};
    rst_n = 1'b0; start = 1'b0; op = '0; a = '0; b = '0; m = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9", "done after reset", done, 0);
    check(y == '0, "R9", "y after reset", y, 0);
    rst_n = 1'b1;

    // R1 addition, boundaries and unused codes
    run_op(3'd0, 65520, 65520, 65521, 65519, "R1", 0);
    run_op(3'd0, 0, 0, 65521, 0, "R1", 0);
    run_op(3'd0, 1, 65520, 65521, 0, "R1", 0);
    run_op(3'd5, 100, 200, 257, 43, "R1", 0);
    run_op(3'd6, 12, 12, 13, 11, "R1", 0);
    run_op(3'd7, 3, 4, 13, 7, "R1", 0);
    foreach (mods[k]) begin
      for (int i = 0; i < 4; i++) begin
        mv = mods[k]; av = longint'($urandom) % mv; bv = longint'($urandom) % mv;
        run_op(3'd0, av, bv, mv, (av + bv) % mv, "R1", 0);
      end
    end

    // R5 reduction, b ignored
    run_op(3'd4, 65535, 9999, 13, 65535 % 13, "R5", 0);
    run_op(3'd4, 12, 4321, 13, 12, "R5", 0);
    run_op(3'd4, 65521, 1, 65521, 0, "R5", 0);
    run_op(3'd4, 60000, 65535, 257, 60000 % 257, "R5", 0);

    // R2 multiplication
    run_op(3'd1, 65520, 65535, 65521, (65520 * 65535) % 65521, "R2", 1);
    run_op(3'd1, 1234, 0, 65521, 0, "R2", 1);
    run_op(3'd1, 12, 12, 13, 1, "R2", 1);
    foreach (mods[k]) begin
      for (int i = 0; i < 4; i++) begin
        mv = mods[k]; av = longint'($urandom) % mv; bv = longint'($urandom) & 16'hFFFF;
        run_op(3'd1, av, bv, mv, (av * bv) % mv, "R2", 1);
      end
    end

    // R3 division
    run_op(3'd2, 0, 77, 65521, 0, "R3", 0);
    run_op(3'd2, 4321, 1, 65521, 4321, "R3", 0);
    run_op(3'd2, 1, 65520, 65521, 65520, "R3", 0);
    foreach (mods[k]) begin
      for (int i = 0; i < 5; i++) begin
        mv = mods[k]; av = longint'($urandom) % mv; bv = 1 + longint'($urandom) % (mv - 1);
        run_op(3'd2, av, bv, mv, (av * inv_mod(bv, mv)) % mv, "R3", 0);
      end
    end

    // R4 inversion, a ignored
    run_op(3'd4 - 3'd1, 65535, 2, 65521, inv_mod(2, 65521), "R4", 0);
    run_op(3'd3, 777, 12, 13, 12, "R4", 0);
    foreach (mods[k]) begin
      for (int i = 0; i < 3; i++) begin
        mv = mods[k]; bv = 1 + longint'($urandom) % (mv - 1);
        run_op(3'd3, longint'($urandom) & 16'hFFFF, bv, mv, inv_mod(bv, mv), "R4", 0);
      end
    end

    // R8 inputs scrambled while busy (every run), tagged case
    run_op(3'd1, 300, 40000, 32749, (300 * 40000) % 32749, "R8", 0);
    run_op(3'd2, 5, 9, 257, (5 * inv_mod(9, 257)) % 257, "R8", 0);

    // R7 start while busy and start in done cycle
    run_op(3'd1, 999, 4321, 65521, (999 * 4321) % 65521, "R7", 2);
    run_op(3'd2, 17, 23, 32749, (17 * inv_mod(23, 32749)) % 32749, "R7", 2);
    run_op(3'd0, 7, 9, 13, 3, "R7", 3);
    run_op(3'd1, 100, 200, 257, (100 * 200) % 257, "R7", 3);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6", "pending results", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule